// File: doc/BRIEF.md
# Shifted-Pattern Bitfield Unit

This block is the bit-manipulation datapath of a 32-bit integer core. In one pass it combines a destination operand with a source pattern. The pattern is first moved left by an index taken from a control operand. Five operations are available. A probe ANDs the two operands and keeps only the flags. Set ORs the pattern in. Clear removes the destination bits where the pattern is one. Invert toggles pattern-selected bits inside a window of a given length. Extract pulls a right-aligned bitfield out of the pattern operand.

The result path is purely combinational, so the datapath sees it in the same cycle. A write-enable output tells the register file whether the result should be stored. The zero and sign flags sit in registers inside the block. They capture the result at a clock edge only when an operation is issued and the set-flags enable is high. Register-file access and opcode decoding belong to the surrounding core.

Top module: `bitfield_unit`

## Requirements
- R1: The shift index is ctl_val[5:0] and the length/MSB field is ctl_val[13:8]. All other control bits are ignored. The shifted pattern is pat_val << index, and it is all zero when the index is 32 or more. op_sel codes are 0 probe, 1 set, 2 clear, 3 invert and 4 extract. Codes 5 to 7 are reserved.
- R2: Probe (0) drives result = dst_val & shifted pattern and holds wr_en low.
- R3: Set (1) drives result = dst_val | shifted pattern, and wr_en follows op_valid.
- R4: Clear (2) drives result = dst_val & ~shifted pattern, and wr_en follows op_valid.
- R5: Invert (3) drives result = dst_val ^ (shifted pattern & window). The window covers bits index up to index+length-1.
- R6: For invert, a length of zero makes the window run from the index to bit 31. A window that would pass bit 31 stops at bit 31. An index of 32 or more gives an empty window.
- R7: Extract (4) returns pat_val bits from position ctl_val[13:8] down to ctl_val[5:0], moved so that the lowest of them lands at bit 0. The upper bits are zero.
- R8: For extract, an MSB of 32 or more is treated as 31. The result is zero when the MSB is below the LSB or when the LSB is 32 or more.
- R9: On a clock edge with op_valid and set_flags_en both high and a defined opcode, flag_z takes (result == 0) and flag_s takes result[31].
- R10: Flags keep their value when op_valid or set_flags_en is low, or when the opcode is reserved. A reserved opcode also passes dst_val to result with wr_en low.
- R11: An asynchronous low rst_n clears flag_z and flag_s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_sel | input | 3 | Operation code |
| dst_val | input | 32 | Destination operand |
| pat_val | input | 32 | Source pattern operand |
| ctl_val | input | 32 | Index and length/MSB control operand |
| set_flags_en | input | 1 | Allows the flags to be updated |
| result | output | 32 | Combinational operation result |
| wr_en | output | 1 | Result should be written back |
| flag_z | output | 1 | Registered zero flag |
| flag_s | output | 1 | Registered sign flag |

## Verification
Two things can happen in one cycle: the flag registers capture the previous operation, and the combinational result already shows the next one. The bench issues two operations back to back. Just after the clock edge it checks that flag_z and flag_s match the first operation's result while result already matches the second. A further pair of back-to-back operations holds set_flags_en low for the second. This shows that the second result, though visible at once, leaves the flags at the first operation's values.

// File: rtl/bitfield_unit_pkg.sv
package bitfield_unit_pkg;

   typedef enum logic [2:0] {
      BFU_PROBE   = 3'd0,
      BFU_SET     = 3'd1,
      BFU_CLEAR   = 3'd2,
      BFU_INVERT  = 3'd3,
      BFU_EXTRACT = 3'd4
   } bfu_op_e;

   localparam int BFU_OP_W = 3;

   function automatic logic bfu_op_defined(input logic [BFU_OP_W-1:0] op);
      return op <= BFU_OP_W'(BFU_EXTRACT);
   endfunction

   function automatic logic bfu_op_writes(input logic [BFU_OP_W-1:0] op);
      return (op != BFU_OP_W'(BFU_PROBE)) && bfu_op_defined(op);
   endfunction

endpackage

// File: rtl/bfu_shift.sv
module bfu_shift #(
   parameter int DATA_W = 32,
   parameter bit LEFT   = 1'b1,
   parameter bit STAGED = 1'b1
) (
   input  logic [DATA_W-1:0]          din,
   input  logic [$clog2(DATA_W):0]    amt,
   output logic [DATA_W-1:0]          dout
);
   localparam int SW = $clog2(DATA_W);

   logic [DATA_W-1:0] shifted;

   generate
      if (STAGED) begin : g_staged
         logic [DATA_W-1:0] stg [SW+1];
         assign stg[0] = din;
         for (genvar k = 0; k < SW; k++) begin : g_stage
            if (LEFT) begin : g_l
               assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
            end else begin : g_r
               assign stg[k+1] = amt[k] ? (stg[k] >> (1 << k)) : stg[k];
            end
         end
         assign shifted = stg[SW];
      end else begin : g_operator
         if (LEFT) begin : g_l
            assign shifted = din << amt[SW-1:0];
         end else begin : g_r
            assign shifted = din >> amt[SW-1:0];
         end
      end
   endgenerate

   // Amounts of DATA_W or more push every bit out.
   assign dout = amt[SW] ? '0 : shifted;

endmodule

// File: rtl/bfu_field_mask.sv
module bfu_field_mask #(
   parameter int DATA_W = 32
) (
   input  logic                        en,
   input  logic [$clog2(DATA_W)-1:0]   lo,
   input  logic [$clog2(DATA_W)-1:0]   hi,
   output logic [DATA_W-1:0]           mask
);
   localparam int SW = $clog2(DATA_W);

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         localparam logic [SW-1:0] POS = SW'(i);
         assign mask[i] = en && (POS >= lo) && (POS <= hi);
      end
   endgenerate

endmodule

// File: rtl/bfu_flag_reg.sv
module bfu_flag_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [DATA_W-1:0] res,
   output logic              zf,
   output logic              sf
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zf <= 1'b0;
         sf <= 1'b0;
      end else if (upd) begin
         zf <= (res == '0);
         sf <= res[DATA_W-1];
      end
   end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
   import bitfield_unit_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IDX_POS = 0,
   parameter int FLD_POS = 8,
   parameter bit STAGED  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] pat_val,
   input  logic [DATA_W-1:0] ctl_val,
   input  logic              set_flags_en,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              flag_z,
   output logic              flag_s
);
   localparam int SW = $clog2(DATA_W);
   localparam int CW = SW + 1;
   localparam logic [SW-1:0] TOP_BIT = SW'(DATA_W - 1);
   localparam logic [CW:0]   WIDTH_X = (CW+1)'(DATA_W);

   generate
      if ((1 << SW) != DATA_W || DATA_W < 8) begin : g_bad_width
         $error("bitfield_unit: DATA_W must be a power of two of at least 8");
      end
      if (FLD_POS < IDX_POS + CW || FLD_POS + CW > DATA_W) begin : g_bad_fields
         $error("bitfield_unit: control fields overlap or exceed DATA_W");
      end
   endgenerate

   logic [CW-1:0]     idx;
   logic [CW-1:0]     fld;
   logic [DATA_W-1:0] pat_sh;

   assign idx = ctl_val[IDX_POS +: CW];
   assign fld = ctl_val[FLD_POS +: CW];

   bfu_shift #(.DATA_W(DATA_W), .LEFT(1'b1), .STAGED(STAGED)) u_lsh (
      .din (pat_val),
      .amt (idx),
      .dout(pat_sh)
   );

   // Invert window: idx .. idx+len-1, clipped at the top bit.
   logic [CW:0]       inv_end;
   logic [SW-1:0]     inv_hi;
   logic              inv_en;
   logic [DATA_W-1:0] inv_mask;

   always_comb begin
      inv_end = {1'b0, idx} + {1'b0, fld} - (CW+1)'(1);
      if (fld == '0 || inv_end >= WIDTH_X) inv_hi = TOP_BIT;
      else                                 inv_hi = inv_end[SW-1:0];
      inv_en = !idx[SW];
   end

   bfu_field_mask #(.DATA_W(DATA_W)) u_inv_mask (
      .en  (inv_en),
      .lo  (idx[SW-1:0]),
      .hi  (inv_hi),
      .mask(inv_mask)
   );

   // Extract window: msb .. lsb, msb clipped, empty when inverted.
   logic [SW-1:0]     ext_hi;
   logic              ext_en;
   logic [DATA_W-1:0] ext_mask;
   logic [DATA_W-1:0] ext_val;

   always_comb begin
      ext_hi = fld[SW] ? TOP_BIT : fld[SW-1:0];
      ext_en = !idx[SW] && (ext_hi >= idx[SW-1:0]);
   end

   bfu_field_mask #(.DATA_W(DATA_W)) u_ext_mask (
      .en  (ext_en),
      .lo  (idx[SW-1:0]),
      .hi  (ext_hi),
      .mask(ext_mask)
   );

   bfu_shift #(.DATA_W(DATA_W), .LEFT(1'b0), .STAGED(STAGED)) u_rsh (
      .din (pat_val & ext_mask),
      .amt (idx),
      .dout(ext_val)
   );

   always_comb begin
      unique case (op_sel)
         BFU_OP_W'(BFU_PROBE):   result = dst_val & pat_sh;
         BFU_OP_W'(BFU_SET):     result = dst_val | pat_sh;
         BFU_OP_W'(BFU_CLEAR):   result = dst_val & ~pat_sh;
         BFU_OP_W'(BFU_INVERT):  result = dst_val ^ (pat_sh & inv_mask);
         BFU_OP_W'(BFU_EXTRACT): result = ext_val;
         default:                result = dst_val;
      endcase
   end

   assign wr_en = op_valid && bfu_op_writes(op_sel);

   logic flag_upd;
   assign flag_upd = op_valid && set_flags_en && bfu_op_defined(op_sel);

   bfu_flag_reg #(.DATA_W(DATA_W)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (flag_upd),
      .res  (result),
      .zf   (flag_z),
      .sf   (flag_s)
   );

endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int IDX_POS = 0,
   parameter int FLD_POS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_sel,
   input logic [DATA_W-1:0] dst_val,
   input logic [DATA_W-1:0] ctl_val,
   input logic              set_flags_en,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic              flag_z,
   input logic              flag_s
);
   localparam int CW = $clog2(DATA_W) + 1;

   logic [CW-1:0] c_lsb, c_msb;
   logic          c_upd;
   assign c_lsb = ctl_val[IDX_POS +: CW];
   assign c_msb = ctl_val[FLD_POS +: CW];
   assign c_upd = op_valid && set_flags_en && (op_sel <= 3'd4);

   AST_PROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd0) |-> !wr_en); // R2
   AST_SET_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd1) |-> ((result & dst_val) == dst_val)); // R3
   AST_CLEAR_NO_NEW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd2) |-> ((result & ~dst_val) == '0)); // R4
   AST_EXTRACT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd4 && c_msb < c_lsb) |-> (result == '0)); // R8
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      c_upd |=> (flag_z == ($past(result) == '0))); // R9
   AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      c_upd |=> (flag_s == $past(result[DATA_W-1]))); // R9
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !c_upd |=> $stable({flag_z, flag_s})); // R10
   AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > 3'd4) |-> (result == dst_val && !wr_en)); // R10

endmodule

bind bitfield_unit bitfield_unit_chk #(
   .DATA_W (DATA_W),
   .IDX_POS(IDX_POS),
   .FLD_POS(FLD_POS)
) u_chk (.*);

// File: tb/sim_bitfield_unit.sv
module sim_bitfield_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic [31:0] dst_val = '0, pat_val = '0, ctl_val = '0;
   logic        set_flags_en = 1'b0;
   logic [31:0] result;
   logic        wr_en, flag_z, flag_s;

   int n_checks = 0;
   int n_fail   = 0;
   logic mz = 1'b0, ms = 1'b0;

   always #2 clk = ~clk;

   bitfield_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .dst_val(dst_val), .pat_val(pat_val), .ctl_val(ctl_val),
      .set_flags_en(set_flags_en), .result(result), .wr_en(wr_en),
      .flag_z(flag_z), .flag_s(flag_s)
   );

   // {op, dst, pat, ctl, expected result}
   localparam logic [130:0] VEC [17] = '{
      {3'd0, 32'hFFFF0000, 32'h0000000F, 32'h00000010, 32'h000F0000}, // R2
      {3'd0, 32'h0000FFFF, 32'h0000000F, 32'h00000010, 32'h00000000}, // R2
      {3'd1, 32'h12340000, 32'h000000FF, 32'h00000008, 32'h1234FF00}, // R3
      {3'd1, 32'h00000005, 32'h00000001, 32'h00000028, 32'h00000005}, // R1
      {3'd1, 32'h00000000, 32'h00000001, 32'hFFFFC004, 32'h00000010}, // R1
      {3'd2, 32'hFFFFFFFF, 32'h0000000F, 32'h00000004, 32'hFFFFFF0F}, // R4
      {3'd2, 32'hFFFFFFFF, 32'h00000003, 32'h0000001F, 32'h7FFFFFFF}, // R4
      {3'd3, 32'h00000000, 32'hFFFFFFFF, 32'h00000804, 32'h00000FF0}, // R5
      {3'd3, 32'h00000000, 32'hFFFFFFFF, 32'h00000A1C, 32'hF0000000}, // R6
      {3'd3, 32'hFFFFFFFF, 32'h00000005, 32'h00000000, 32'hFFFFFFFA}, // R6
      {3'd3, 32'h0000000F, 32'h00000001, 32'h00000102, 32'h0000000B}, // R5
      {3'd4, 32'h00000000, 32'hABCD1234, 32'h00000F08, 32'h00000012}, // R7
      {3'd4, 32'h00000000, 32'h80000000, 32'h0000281F, 32'h00000001}, // R8
      {3'd4, 32'h00000000, 32'hFFFFFFFF, 32'h00000408, 32'h00000000}, // R8
      {3'd4, 32'h00000000, 32'hDEADBEEF, 32'h00001F00, 32'hDEADBEEF}, // R7
      {3'd4, 32'h00000000, 32'hFFFFFFFF, 32'h00001F25, 32'h00000000}, // R8
      {3'd5, 32'hCAFEF00D, 32'h12345678, 32'h00000000, 32'hCAFEF00D}  // R10
   };

   function automatic string rtag(input logic [2:0] op);
      case (op)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5/R6";
         3'd4: return "R7/R8";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input logic ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic check_flags(input string req);
      check(flag_z == mz && flag_s == ms, req,
            {30'd0, flag_z, flag_s}, {30'd0, mz, ms});
   endtask

   task automatic issue(input logic [2:0] op, input logic [31:0] d,
                        input logic [31:0] p, input logic [31:0] c,
                        input logic sf);
      op_valid = 1'b1; op_sel = op; dst_val = d; pat_val = p;
      ctl_val = c; set_flags_en = sf;
   endtask

   initial begin
      #(4 * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_flags("R11 reset");
      rst_n = 1'b1;

      // Table walk: result, write enable, then flags after the edge.
      for (int v = 0; v < 17; v++) begin
         logic [2:0]  op;
         logic [31:0] d, p, c, e;
         {op, d, p, c, e} = VEC[v];
         @(posedge clk); #1;
         issue(op, d, p, c, 1'b1);
         @(negedge clk);
         check(result == e, rtag(op), result, e);
         check(wr_en == (op >= 3'd1 && op <= 3'd4), rtag(op),
               {31'd0, wr_en}, {31'd0, (op >= 3'd1 && op <= 3'd4)});
         if (op <= 3'd4) begin mz = (e == 0); ms = e[31]; end
         @(posedge clk); #1;
         check_flags(op <= 3'd4 ? "R9" : "R10");
      end

      // Same cycle: flags capture op A while result already shows op B.
      issue(3'd1, 32'h80000000, 32'h0, 32'h0, 1'b1);      // A: negative
      @(posedge clk); #1;
      mz = 1'b0; ms = 1'b1;
      issue(3'd2, 32'h0000000F, 32'h0000000F, 32'h0, 1'b1); // B: zero
      #0.5;
      check_flags("R9 flags from previous op");
      check(result == 32'h0, "R4 current op", result, 32'h0);
      @(posedge clk); #1;
      mz = 1'b1; ms = 1'b0;
      check_flags("R9 back-to-back");

      // Flags gated off: nonzero negative result, flags must hold.
      issue(3'd1, 32'h0, 32'h0000000F, 32'h0000001C, 1'b0);
      @(negedge clk);
      check(result == 32'hF0000000, "R3", result, 32'hF0000000);
      @(posedge clk); #1;
      check_flags("R10 set_flags_en low");

      // Not valid: no write, flags hold.
      op_valid = 1'b0; set_flags_en = 1'b1;
      @(negedge clk);
      check(wr_en == 1'b0, "R3 no valid", {31'd0, wr_en}, 32'd0);
      @(posedge clk); #1;
      check_flags("R10 op_valid low");

      // Invert with index past the top: window empty.
      issue(3'd3, 32'h12345678, 32'hFFFFFFFF, 32'h00000520, 1'b1);
      @(negedge clk);
      check(result == 32'h12345678, "R6 empty window", result, 32'h12345678);

      // Mid-run reset clears flags.
      issue(3'd1, 32'h80000000, 32'h0, 32'h0, 1'b1);
      @(posedge clk); #1;
      mz = 1'b0; ms = 1'b1;
      check_flags("R9");
      rst_n = 1'b0; op_valid = 1'b0;
      #1;
      mz = 1'b0; ms = 1'b0;
      check_flags("R11 async reset");
      @(posedge clk); #1;
      rst_n = 1'b1;

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule